// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns one free-running input clock into two phase clocks for a latch-based pipeline. The master phase drives master latches. The slave phase drives slave latches. The two phases are never high at the same time. One edge-triggered state register, clocked on the rising input edge, chooses which phase may pulse in the current input period. A gate stage then lets that phase through only while the input clock is low. The register output is stable for the whole low half, so the pulses cannot glitch. The phases take turns: one input period belongs to the slave phase, the next to the master phase. Each phase therefore runs at half the input rate, and so does the latch pipeline it drives.

The sequencer has three named states. `PS_HOLD` is entered whenever reset is high and lets neither phase pulse. `PS_SLAVE` lets the slave phase pulse. `PS_MASTER` lets the master phase pulse. It has three transitions. Reset forces `PS_HOLD` from any state, asynchronously. `PS_HOLD` moves to `PS_SLAVE` on the first rising edge at which reset is low. From then on, `PS_SLAVE` and `PS_MASTER` swap on every rising edge. A status output shows whether the current period belongs to the master phase. Downstream logic reads it during the high half to learn which phase will pulse in the following low half.

Top module: `twophase_clkgen`

## Requirements
- R1: The master phase output and the slave phase output are never high at the same instant.
- R2: While reset is high, both phase outputs and the select output are 0. Reset takes effect at once, without waiting for a clock edge, and ends any pulse that is under way.
- R3: After reset is released, the first rising input edge starts a slave period. The first pulse is on the slave phase, in the low half of that period.
- R4: Once running, slave periods and master periods alternate on every rising input edge. Each phase pulses exactly once in every two input periods.
- R5: A phase output can be high only while the input clock is low. During the high half of every period, both phase outputs are 0.
- R6: The select output is 1 exactly during master periods and 0 during slave periods and in reset. A 1 means the master phase pulses in the low half of the current period.
- R7: Between the end of a pulse on one phase and the start of a pulse on the other, there is a gap of at least half an input period with both phases low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running input clock |
| rst_in | input | 1 | Active-high asynchronous reset |
| ph_master_o | output | 1 | Master-latch phase clock |
| ph_slave_o | output | 1 | Slave-latch phase clock |
| sel_master_o | output | 1 | High during periods that belong to the master phase |

## Verification
The outputs are sampled twice in each input period: once in the middle of the high half and once in the middle of the low half. This separates "pulse only while the clock is low" from "which phase pulses". It also catches a phase that is gated by the wrong clock level.

The bench runs three stimulus patterns:
- a long uninterrupted run, which shows strict alternation and the matching select value;
- a clean release from reset, which shows that the slave phase comes first;
- reset asserted in the middle of a master pulse, followed by a second release, which shows that the pulse is cut off at once and that the sequence restarts on the slave phase, whatever the previous state was.

A level-change monitor on the two phase outputs looks for any overlap.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    // Number of phase clocks produced; index 0 is slave, index 1 is master.
    localparam int unsigned N_PHASES  = 2;
    localparam int unsigned IDX_SLAVE = 0;
    localparam int unsigned IDX_MASTER = 1;
    localparam int unsigned ST_W      = $clog2(N_PHASES + 1);

    typedef enum logic [ST_W-1:0] {
        PS_HOLD   = 2'd0,
        PS_SLAVE  = 2'd1,
        PS_MASTER = 2'd2
    } phase_state_e;

endpackage

// File: rtl/tpc_seq.sv
module tpc_seq
    import tpc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    output logic [N_PHASES-1:0] en_o,
    output logic                sel_o
);

    phase_state_e state_q;
    phase_state_e state_d;

    // State register: the single edge-sensitive element of the scheme.
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= PS_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_HOLD:   state_d = PS_SLAVE;
            PS_SLAVE:  state_d = PS_MASTER;
            PS_MASTER: state_d = PS_SLAVE;
            default:   state_d = PS_HOLD;
        endcase
    end

    // Output decode: one-hot phase enable and master-select status.
    always_comb begin
        en_o  = '0;
        sel_o = 1'b0;
        unique case (state_q)
            PS_HOLD: begin
                en_o  = '0;
                sel_o = 1'b0;
            end
            PS_SLAVE: begin
                en_o[IDX_SLAVE] = 1'b1;
                sel_o           = 1'b0;
            end
            PS_MASTER: begin
                en_o[IDX_MASTER] = 1'b1;
                sel_o            = 1'b1;
            end
            default: begin
                en_o  = '0;
                sel_o = 1'b0;
            end
        endcase
    end

    // R2
    reset_sel_low_chk: assert property (@(posedge clk_i)
        rst_i |-> (!sel_o && (en_o == '0)));

    // R6
    sel_tracks_master_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_o[IDX_MASTER] |=> !sel_o);

    // R4
    en_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(en_o));

endmodule

// File: rtl/tpc_gate.sv
module tpc_gate
    import tpc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [N_PHASES-1:0] en_i,
    output logic [N_PHASES-1:0] ph_o
);

    // Each phase may only pass while the input clock is low. The enable
    // changes on the rising edge, so it is stable through the low half.
    for (genvar g = 0; g < N_PHASES; g++) begin : g_phase
        assign ph_o[g] = en_i[g] & ~clk_i;
    end

    // R1
    always_comb begin
        if (!rst_i) begin
            no_overlap_chk: assert (!(ph_o[IDX_MASTER] && ph_o[IDX_SLAVE]));
        end
    end

    // R5
    high_half_quiet_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        ph_o == '0);

endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen
    import tpc_pkg::*;
(
    input  logic clk_in,
    input  logic rst_in,
    output logic ph_master_o,
    output logic ph_slave_o,
    output logic sel_master_o
);

    logic [N_PHASES-1:0] en;
    logic [N_PHASES-1:0] ph;

    tpc_seq u_seq (
        .clk_i (clk_in),
        .rst_i (rst_in),
        .en_o  (en),
        .sel_o (sel_master_o)
    );

    tpc_gate u_gate (
        .clk_i (clk_in),
        .rst_i (rst_in),
        .en_i  (en),
        .ph_o  (ph)
    );

    assign ph_master_o = ph[IDX_MASTER];
    assign ph_slave_o  = ph[IDX_SLAVE];

    // R4
    slave_then_master_chk: assert property (@(posedge clk_in) disable iff (rst_in)
        ph_slave_o |=> ph_master_o);

    // R4
    master_then_slave_chk: assert property (@(posedge clk_in) disable iff (rst_in)
        ph_master_o |=> ph_slave_o);

    // R3
    first_is_slave_chk: assert property (@(posedge clk_in) disable iff (rst_in)
        $fell(rst_in) |=> (ph_slave_o && !ph_master_o));

    // R6
    sel_matches_phase_chk: assert property (@(posedge clk_in) disable iff (rst_in)
        ph_master_o |-> sel_master_o);

endmodule

// File: tb/sim_twophase_clkgen.sv
module sim_twophase_clkgen;

    logic clk_in = 1'b0;
    logic rst_in = 1'b1;
    logic ph_master_o;
    logic ph_slave_o;
    logic sel_master_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // 50 MHz: 20 ns period, rising edges at 10, 30, 50, ...
    always #10 clk_in = ~clk_in;

    twophase_clkgen u0 (
        .clk_in       (clk_in),
        .rst_in       (rst_in),
        .ph_master_o  (ph_master_o),
        .ph_slave_o   (ph_slave_o),
        .sel_master_o (sel_master_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // R1: overlap monitor on every level change of either phase
    always @(ph_master_o or ph_slave_o) begin
        if (!done) begin
            check("R1", "overlap", int'(ph_master_o && ph_slave_o), 0);
        end
    end

    // One input period. kind: 0 none, 1 slave, 2 master.
    // Returns at edge+15 ns (middle of low half).
    task automatic period(input int kind, input string req);
        @(posedge clk_in);
        #5;
        check("R5", "master in high half", int'(ph_master_o), 0);
        check("R5", "slave in high half", int'(ph_slave_o), 0);
        check("R6", {req, " select"}, int'(sel_master_o), int'(kind == 2));
        #10;
        check(req, "master in low half", int'(ph_master_o), int'(kind == 2));
        check(req, "slave in low half", int'(ph_slave_o), int'(kind == 1));
    endtask

    task automatic t_reset_hold();
        for (int i = 0; i < 3; i++) period(0, "R2");
    endtask

    task automatic t_release();
        rst_in = 1'b0;           // mid low half of a hold period
        period(1, "R3");
        period(2, "R4");
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 12; i++) period((i % 2 == 0) ? 1 : 2, "R4");
    endtask

    task automatic t_gap();
        // R7: master pulse ends at rising edge; slave cannot start before next low half
        @(posedge clk_in);
        #1;
        check("R7", "slave after master end", int'(ph_slave_o), 0);
        #8;
        check("R7", "slave late high half", int'(ph_slave_o), 0);
        #6;
        check("R7", "slave in its low half", int'(ph_slave_o), 1);
        period(2, "R4");
    endtask

    task automatic t_midreset();
        check("R2", "master before reset", int'(ph_master_o), 1);
        rst_in = 1'b1;
        #1;
        check("R2", "master cut by reset", int'(ph_master_o), 0);
        check("R2", "slave in reset", int'(ph_slave_o), 0);
        check("R2", "select in reset", int'(sel_master_o), 0);
        #4;
        for (int i = 0; i < 2; i++) period(0, "R2");
        rst_in = 1'b0;
        period(1, "R3");
        period(2, "R4");
        period(1, "R4");
    endtask

    initial begin
        #5;
        check("R2", "master at start", int'(ph_master_o), 0);
        check("R2", "slave at start", int'(ph_slave_o), 0);
        check("R2", "select at start", int'(sel_master_o), 0);
        t_reset_hold();
        t_release();
        t_alternate();
        // last alternate period was master; next is slave
        t_gap();
        t_midreset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule